// File: doc/BRIEF.md
# Link Interrupt Event Register

This block holds the interrupt events of a serial-bus link controller in one 32-bit word. Single-cycle strobes from the cycle timer, the PHY interface, the asynchronous DMA contexts and the error paths each set a sticky bit. Software reads the word and changes it through two write vectors: a set vector and a clear vector. In both vectors a 1 acts on its bit and a 0 leaves the bit alone. Several bits follow special rules. A bus reset clears the self-ID-complete bit but leaves its shadow copy alone. A fatal-error bit holds back new events from the contexts that caused it. One bit is not stored at all: it is the live OR of a separate isochronous-receive event/mask pair, and that pair lives in the block too.

A mask word has the same layout and also uses set and clear vectors. Bit 31 of the mask is the master enable. The single interrupt line is high when the master enable is set and at least one readable event bit in positions 30..0 meets its mask bit.

Top module: `link_irq_event_reg`

## Requirements
- R1: Event bits 31, 28, 14..10 and every context position from AC up to 6 always read 0, even after a set-vector write of all ones. Mask bits in those positions also read 0, except mask bit 31, which is the master enable.
- R2: A 1 in `ev_set` sets the event bit at the next clock edge and a 1 in `ev_clr` clears it. A 0 in either vector has no effect. When a set request from software or hardware meets a clear of the same bit in the same cycle, the set wins.
- R3: When bit 17 (bus reset) goes from 0 to 1, bit 16 (self-ID complete) is 0 after that edge, even if bit 16 is set in the same cycle. A new bus-reset request while bit 17 is already 1 does not clear bit 16.
- R4: Every set request to bit 16 also sets bit 15 (self-ID shadow). Bit 15 is only cleared by a clear-vector write, never by a bus reset.
- R5: Bit 7 equals the OR over contexts of (`iso_ev_rd` AND `iso_mask_rd`) with no added delay. `ev_set` and `ev_clr` do not affect bit 7. `iso_rx_strobe` sets the isochronous events and `iso_ev_clr` clears them (set wins). `iso_mask_we` loads the mask from `iso_mask_wdata`.
- R6: Any bit of `ctx_dead` sets bit 24 (fatal) and records the flagged contexts as culprits. While bit 24 is set, `ctx_evt` strobes for culprit contexts (event bits AC-1..0) are ignored, and other contexts still set their bits. Clearing bit 24 forgets the culprits.
- R7: Bit 27 (tardy acknowledge) sets only when `tardy_en` is 1 and at least one of `rx_fifo_pending`, `phys_resp_busy` or `tardy_ack_sent` is 1.
- R8: Bit 30 (vendor) sets when `gp_irq[i]` and `gp_irq_en[i]` are both 1 for i = 0 or 1.
- R9: Bit 29 (software interrupt) has no hardware source. It is set only through `ev_set`.
- R10: The mask word follows the same set/clear rules as the event word (set wins). `irq` = `mask_rd[31]` AND OR over bits 30..0 of (`ev_rd` AND `mask_rd`), with no added delay.
- R11: While `rst_n` is low, all event, mask and isochronous state is 0 and `irq` is 0.
- R12: `evt_strobe` sets only bits 26, 25, 23..16, 9 and 8. A 1 in any other position of `evt_strobe` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | 32 | Direct event strobes, by bit position |
| ctx_evt | input | AC | Normal event strobe per asynchronous context |
| ctx_dead | input | AC | Fatal stop strobe per asynchronous context |
| tardy_en | input | 1 | Enables tardy-acknowledge reporting |
| rx_fifo_pending | input | 1 | Receive FIFO holds data for the host |
| phys_resp_busy | input | 1 | Physical response unit busy |
| tardy_ack_sent | input | 1 | A tardy acknowledge was sent |
| gp_irq | input | 2 | General-purpose interrupt inputs |
| gp_irq_en | input | 2 | Per-input enables for gp_irq |
| iso_rx_strobe | input | IC | Isochronous receive event strobes |
| iso_ev_clr | input | IC | Clear vector for isochronous events |
| iso_mask_we | input | 1 | Load strobe for isochronous mask |
| iso_mask_wdata | input | IC | New isochronous mask value |
| ev_set | input | 32 | Event set vector |
| ev_clr | input | 32 | Event clear vector |
| mask_set | input | 32 | Mask set vector |
| mask_clr | input | 32 | Mask clear vector |
| ev_rd | output | 32 | Event word read value |
| mask_rd | output | 32 | Mask word read value |
| iso_ev_rd | output | IC | Isochronous event bits |
| iso_mask_rd | output | IC | Isochronous mask bits |
| irq | output | 1 | Master interrupt line |

## Verification
Every stored bit is readable on `ev_rd` or `mask_rd` one edge after the stimulus, so a wrong internal state shows up in the very next sample, and the bench compares against its reference model on every clock. The coupled rules depend on hidden state. A culprit record that is wrong only appears when a later context strobe is wrongly dropped or wrongly kept. A wrong bus-reset edge detector only appears when bit 17 is set again while it is already 1. The bench therefore drives those exact sequences. Because `irq` and bit 7 are combinational from stored state, an error in the gating shows on the same sample as the state it reads.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;
  localparam int EW = 32;

  localparam int B_MASTER    = 31;
  localparam int B_VENDOR    = 30;
  localparam int B_SOFT      = 29;
  localparam int B_TARDY     = 27;
  localparam int B_FATAL     = 24;
  localparam int B_BUSRST    = 17;
  localparam int B_SID       = 16;
  localparam int B_SID2      = 15;
  localparam int B_ISO_SUM   = 7;

  // Positions that a plain strobe on evt_strobe may set.
  localparam logic [EW-1:0] DIRECT_MASK = 32'h06FF_0300;
  // Stored positions other than the per-context field.
  localparam logic [EW-1:0] FIXED_LATCHED = 32'h6FFF_8300;

  function automatic logic [EW-1:0] ctx_field(input int ac);
    ctx_field = (32'h1 << ac) - 32'h1;
  endfunction

  function automatic logic [EW-1:0] latched_mask(input int ac);
    latched_mask = FIXED_LATCHED | ctx_field(ac);
  endfunction

  function automatic logic [EW-1:0] readable_mask(input int ac);
    readable_mask = latched_mask(ac) | (32'h1 << B_ISO_SUM);
  endfunction

  function automatic logic [EW-1:0] mask_storage(input int ac);
    mask_storage = readable_mask(ac) | (32'h1 << B_MASTER);
  endfunction

  // Sticky update: set wins over clear.
  function automatic logic [EW-1:0] sticky_next(input logic [EW-1:0] cur,
                                                input logic [EW-1:0] setv,
                                                input logic [EW-1:0] clrv,
                                                input logic [EW-1:0] keep);
    sticky_next = ((cur & ~clrv) | setv) & keep;
  endfunction

  function automatic logic gated_hit(input logic [EW-1:0] ev,
                                     input logic [EW-1:0] msk);
    gated_hit = msk[B_MASTER] & (|(ev[EW-2:0] & msk[EW-2:0]));
  endfunction
endpackage

// File: rtl/irq_src_collect.sv
module irq_src_collect
  import link_irq_pkg::*;
#(
  parameter int AC = 4
) (
  input  logic [EW-1:0] evt_strobe,
  input  logic [AC-1:0] ctx_evt,
  input  logic [AC-1:0] ctx_dead,
  input  logic          tardy_en,
  input  logic          rx_fifo_pending,
  input  logic          phys_resp_busy,
  input  logic          tardy_ack_sent,
  input  logic [1:0]    gp_irq,
  input  logic [1:0]    gp_irq_en,
  input  logic          fatal_q,
  input  logic [AC-1:0] fatal_ctx_q,
  output logic [EW-1:0] hw_set,
  output logic [AC-1:0] ctx_blocked
);
  logic tardy_cond;
  logic vendor_cond;

  assign tardy_cond  = tardy_en & (rx_fifo_pending | phys_resp_busy | tardy_ack_sent);
  assign vendor_cond = |(gp_irq & gp_irq_en);

  for (genvar c = 0; c < AC; c++) begin : g_block
    assign ctx_blocked[c] = fatal_q & fatal_ctx_q[c];
  end

  always_comb begin
    hw_set           = evt_strobe & DIRECT_MASK;
    hw_set[B_VENDOR] = vendor_cond;
    hw_set[B_TARDY]  = tardy_cond;
    hw_set[B_FATAL]  = |ctx_dead;
    for (int c = 0; c < AC; c++) begin
      hw_set[c] = ctx_evt[c] & ~ctx_blocked[c];
    end
  end
endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
  import link_irq_pkg::*;
#(
  parameter int AC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] hw_set,
  input  logic [EW-1:0] ev_set,
  input  logic [EW-1:0] ev_clr,
  input  logic [AC-1:0] ctx_dead,
  output logic [EW-1:0] ev_q,
  output logic [AC-1:0] fatal_ctx_q,
  output logic          busrst_rise
);
  localparam logic [EW-1:0] KEEP = latched_mask(AC);

  logic [EW-1:0] set_req;
  logic [EW-1:0] ev_d;
  logic [AC-1:0] fatal_ctx_d;

  always_comb begin
    set_req = (hw_set | ev_set) & KEEP;
    if (set_req[B_SID]) set_req[B_SID2] = 1'b1;
  end

  assign busrst_rise = set_req[B_BUSRST] & ~ev_q[B_BUSRST];

  always_comb begin
    ev_d = sticky_next(ev_q, set_req, ev_clr, KEEP);
    if (busrst_rise) ev_d[B_SID] = 1'b0;
    fatal_ctx_d = ev_d[B_FATAL] ? (fatal_ctx_q | ctx_dead) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q        <= '0;
      fatal_ctx_q <= '0;
    end else begin
      ev_q        <= ev_d;
      fatal_ctx_q <= fatal_ctx_d;
    end
  end
endmodule

// File: rtl/iso_rx_summary.sv
module iso_rx_summary #(
  parameter int IC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IC-1:0] iso_rx_strobe,
  input  logic [IC-1:0] iso_ev_clr,
  input  logic          iso_mask_we,
  input  logic [IC-1:0] iso_mask_wdata,
  output logic [IC-1:0] iso_ev_q,
  output logic [IC-1:0] iso_mask_q,
  output logic          iso_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_ev_q   <= '0;
      iso_mask_q <= '0;
    end else begin
      iso_ev_q <= (iso_ev_q & ~iso_ev_clr) | iso_rx_strobe;
      if (iso_mask_we) iso_mask_q <= iso_mask_wdata;
    end
  end

  assign iso_hit = |(iso_ev_q & iso_mask_q);
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
  import link_irq_pkg::*;
#(
  parameter int AC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] mask_set,
  input  logic [EW-1:0] mask_clr,
  input  logic [EW-1:0] ev_word,
  output logic [EW-1:0] mask_q,
  output logic          irq
);
  localparam logic [EW-1:0] KEEP = mask_storage(AC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= sticky_next(mask_q, mask_set, mask_clr, KEEP);
  end

  assign irq = gated_hit(ev_word, mask_q);
endmodule

// File: rtl/link_irq_event_reg.sv
module link_irq_event_reg
  import link_irq_pkg::*;
#(
  parameter int AC = 4,
  parameter int IC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   evt_strobe,
  input  logic [AC-1:0] ctx_evt,
  input  logic [AC-1:0] ctx_dead,
  input  logic          tardy_en,
  input  logic          rx_fifo_pending,
  input  logic          phys_resp_busy,
  input  logic          tardy_ack_sent,
  input  logic [1:0]    gp_irq,
  input  logic [1:0]    gp_irq_en,
  input  logic [IC-1:0] iso_rx_strobe,
  input  logic [IC-1:0] iso_ev_clr,
  input  logic          iso_mask_we,
  input  logic [IC-1:0] iso_mask_wdata,
  input  logic [31:0]   ev_set,
  input  logic [31:0]   ev_clr,
  input  logic [31:0]   mask_set,
  input  logic [31:0]   mask_clr,
  output logic [31:0]   ev_rd,
  output logic [31:0]   mask_rd,
  output logic [IC-1:0] iso_ev_rd,
  output logic [IC-1:0] iso_mask_rd,
  output logic          irq
);
  logic [EW-1:0] hw_set;
  logic [EW-1:0] ev_q;
  logic [AC-1:0] fatal_ctx_q;
  logic [AC-1:0] ctx_blocked;
  logic          busrst_rise;
  logic          iso_hit;

  irq_src_collect #(.AC(AC)) u_src (
    .evt_strobe      (evt_strobe),
    .ctx_evt         (ctx_evt),
    .ctx_dead        (ctx_dead),
    .tardy_en        (tardy_en),
    .rx_fifo_pending (rx_fifo_pending),
    .phys_resp_busy  (phys_resp_busy),
    .tardy_ack_sent  (tardy_ack_sent),
    .gp_irq          (gp_irq),
    .gp_irq_en       (gp_irq_en),
    .fatal_q         (ev_q[B_FATAL]),
    .fatal_ctx_q     (fatal_ctx_q),
    .hw_set          (hw_set),
    .ctx_blocked     (ctx_blocked)
  );

  irq_event_bank #(.AC(AC)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_set      (hw_set),
    .ev_set      (ev_set),
    .ev_clr      (ev_clr),
    .ctx_dead    (ctx_dead),
    .ev_q        (ev_q),
    .fatal_ctx_q (fatal_ctx_q),
    .busrst_rise (busrst_rise)
  );

  iso_rx_summary #(.IC(IC)) u_iso (
    .clk            (clk),
    .rst_n          (rst_n),
    .iso_rx_strobe  (iso_rx_strobe),
    .iso_ev_clr     (iso_ev_clr),
    .iso_mask_we    (iso_mask_we),
    .iso_mask_wdata (iso_mask_wdata),
    .iso_ev_q       (iso_ev_rd),
    .iso_mask_q     (iso_mask_rd),
    .iso_hit        (iso_hit)
  );

  assign ev_rd = ev_q | ({{(EW-1){1'b0}}, iso_hit} << B_ISO_SUM);

  irq_mask_gate #(.AC(AC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .ev_word  (ev_rd),
    .mask_q   (mask_rd),
    .irq      (irq)
  );
endmodule

// File: rtl/link_irq_event_chk.sv
module link_irq_event_chk
  import link_irq_pkg::*;
#(
  parameter int AC = 4,
  parameter int IC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   ev_rd,
  input logic [31:0]   mask_rd,
  input logic [IC-1:0] iso_ev_rd,
  input logic [IC-1:0] iso_mask_rd,
  input logic          irq,
  input logic [31:0]   ev_set,
  input logic [31:0]   ev_clr,
  input logic [AC-1:0] fatal_ctx_q,
  input logic          busrst_rise
);
  localparam logic [31:0] RSVD = ~readable_mask(AC);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd & RSVD) == 32'h0);

  a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[B_SOFT] |=> ev_rd[B_SOFT]);

  a_r3_busrst_clears_sid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_rd[B_BUSRST]) |-> !ev_rd[B_SID]);

  a_r3_rise_only_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    busrst_rise |-> !ev_rd[B_BUSRST]);

  a_r4_shadow_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_rd[B_SID]) |-> ev_rd[B_SID2]);

  a_r4_shadow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd[B_SID2] && !ev_clr[B_SID2]) |=> ev_rd[B_SID2]);

  a_r5_iso_live: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd[B_ISO_SUM] == (|(iso_ev_rd & iso_mask_rd)));

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (mask_rd[B_MASTER] && (|(ev_rd[30:0] & mask_rd[30:0]))));

  for (genvar c = 0; c < AC; c++) begin : g_r6
    a_r6_ctx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd[B_FATAL] && fatal_ctx_q[c] && !ev_rd[c] && !ev_set[c]) |=> !ev_rd[c]);
  end
endmodule

bind link_irq_event_reg link_irq_event_chk #(.AC(AC), .IC(IC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_rd       (ev_rd),
  .mask_rd     (mask_rd),
  .iso_ev_rd   (iso_ev_rd),
  .iso_mask_rd (iso_mask_rd),
  .irq         (irq),
  .ev_set      (ev_set),
  .ev_clr      (ev_clr),
  .fatal_ctx_q (fatal_ctx_q),
  .busrst_rise (busrst_rise)
);

// File: tb/tb_link_irq_event_reg.sv
`timescale 1ns/1ps
module tb_link_irq_event_reg;
  localparam int AC = 4;
  localparam int IC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [31:0]   evt_strobe, ev_set, ev_clr, mask_set, mask_clr;
  logic [AC-1:0] ctx_evt, ctx_dead;
  logic          tardy_en, rx_fifo_pending, phys_resp_busy, tardy_ack_sent;
  logic [1:0]    gp_irq, gp_irq_en;
  logic [IC-1:0] iso_rx_strobe, iso_ev_clr, iso_mask_wdata;
  logic          iso_mask_we;
  logic [31:0]   ev_rd, mask_rd;
  logic [IC-1:0] iso_ev_rd, iso_mask_rd;
  logic          irq;

  link_irq_event_reg #(.AC(AC), .IC(IC)) dut (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R11";

  // Reference state
  logic [31:0]   m_ev, m_mask;
  logic [IC-1:0] m_iso, m_isom;
  logic [AC-1:0] m_culp;

  int direct_bits[12] = '{26, 25, 23, 22, 21, 20, 19, 18, 17, 16, 9, 8};
  int fixed_bits[17]  = '{30, 29, 27, 26, 25, 24, 23, 22, 21, 20, 19, 18, 17, 16, 15, 9, 8};

  function automatic logic [31:0] stored_bits();
    logic [31:0] r = 0;
    foreach (fixed_bits[i]) r[fixed_bits[i]] = 1'b1;
    for (int c = 0; c < AC; c++) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_ev_rd();
    logic [31:0] e = m_ev;
    if ((m_iso & m_isom) != 0) e[7] = 1'b1;
    return e;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] e = exp_ev_rd();
    if (!m_mask[31]) return 1'b0;
    for (int b = 0; b < 31; b++) if (e[b] && m_mask[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_step();
    logic [31:0] s, n, lat;
    lat = stored_bits();
    if (!rst_n) begin
      m_ev = 0; m_mask = 0; m_iso = 0; m_isom = 0; m_culp = 0;
      return;
    end
    s = ev_set;
    foreach (direct_bits[i]) if (evt_strobe[direct_bits[i]]) s[direct_bits[i]] = 1'b1;
    if ((gp_irq[0] && gp_irq_en[0]) || (gp_irq[1] && gp_irq_en[1])) s[30] = 1'b1;
    if (tardy_en && (rx_fifo_pending || phys_resp_busy || tardy_ack_sent)) s[27] = 1'b1;
    if (ctx_dead != 0) s[24] = 1'b1;
    for (int c = 0; c < AC; c++)
      if (ctx_evt[c] && !(m_ev[24] && m_culp[c])) s[c] = 1'b1;
    s = s & lat;
    if (s[16]) s[15] = 1'b1;
    n = ((m_ev & ~ev_clr) | s) & lat;
    if (s[17] && !m_ev[17]) n[16] = 1'b0;
    m_culp = n[24] ? (m_culp | ctx_dead) : '0;
    m_ev   = n;
    m_iso  = (m_iso & ~iso_ev_clr) | iso_rx_strobe;
    if (iso_mask_we) m_isom = iso_mask_wdata;
    m_mask = ((m_mask & ~mask_clr) | mask_set) & (lat | 32'h8000_0080);
  endtask

  task automatic compare_all();
    logic [31:0] e;
    e = exp_ev_rd();
    n_cmp++;
    if (ev_rd !== e || mask_rd !== m_mask || iso_ev_rd !== m_iso ||
        iso_mask_rd !== m_isom || irq !== exp_irq()) begin
      n_bad++;
      $display("FAIL %s: ev %h/%h mask %h/%h iso %h/%h isom %h/%h irq %b/%b (actual/expected)",
               tag, ev_rd, e, mask_rd, m_mask, iso_ev_rd, m_iso,
               iso_mask_rd, m_isom, irq, exp_irq());
    end
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt_strobe = 0; ev_set = 0; ev_clr = 0; mask_set = 0; mask_clr = 0;
    ctx_evt = 0; ctx_dead = 0; tardy_en = 0; rx_fifo_pending = 0;
    phys_resp_busy = 0; tardy_ack_sent = 0; gp_irq = 0; gp_irq_en = 0;
    iso_rx_strobe = 0; iso_ev_clr = 0; iso_mask_we = 0; iso_mask_wdata = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic wipe();
    ev_clr = '1; mask_clr = '1; iso_ev_clr = '1; iso_mask_we = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog %s: run did not end, actual hung expected done", tag);
    finish_run();
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    m_ev = 0; m_mask = 0; m_iso = 0; m_isom = 0; m_culp = 0;
    @(negedge clk);
    // R11: reset holds everything clear, even with stimulus applied
    tag = "R11";
    ev_set = '1; mask_set = '1; iso_rx_strobe = '1;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R11 ev", ev_rd, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);

    // R1: reserved positions never store
    tag = "R1";
    ev_set = '1; mask_set = '1;
    tick();
    chk("R1 ev reserved", ev_rd & 32'h9000_7C70, 32'h0);
    chk("R1 mask reserved", mask_rd & 32'h1000_7C70, 32'h0);
    wipe();

    // R12: full strobe vector; bus reset rises with self-ID so bit 16 drops
    tag = "R12";
    evt_strobe = '1;
    tick();
    chk("R12 direct strobes", ev_rd, 32'h06FE_8300);
    wipe();

    // R3 / R4: bus reset versus self-ID complete
    tag = "R3";
    evt_strobe[16] = 1'b1; tick();
    chk("R3 sid set", ev_rd, 32'h0001_8000);
    evt_strobe[17] = 1'b1; tick();
    chk("R3 busrst clears sid", ev_rd, 32'h0002_8000);
    evt_strobe[16] = 1'b1; tick();
    evt_strobe[17] = 1'b1; tick();
    chk("R3 repeat busrst keeps sid", ev_rd, 32'h0003_8000);
    tag = "R4";
    ev_clr = 32'h0003_0000; tick();
    chk("R4 shadow kept", ev_rd, 32'h0000_8000);
    wipe();

    // R9 / R2: software bit, set beats clear
    tag = "R9";
    ev_set[29] = 1'b1; ev_clr[29] = 1'b1; tick();
    chk("R9 soft set", ev_rd, 32'h2000_0000);
    tag = "R2";
    ev_clr[29] = 1'b1; tick();
    chk("R2 clear", ev_rd, 32'h0);
    evt_strobe[9] = 1'b1; ev_clr[9] = 1'b1; tick();
    chk("R2 hw set beats clear", ev_rd, 32'h0000_0200);
    tick();
    chk("R2 zero writes no effect", ev_rd, 32'h0000_0200);
    wipe();

    // R5: live isochronous summary
    tag = "R5";
    iso_rx_strobe = 4'b0101; tick();
    chk("R5 unmasked", ev_rd, 32'h0);
    iso_mask_we = 1'b1; iso_mask_wdata = 4'b0100; tick();
    chk("R5 masked hit", ev_rd, 32'h0000_0080);
    ev_clr[7] = 1'b1; tick();
    chk("R5 clear port ignored", ev_rd, 32'h0000_0080);
    iso_ev_clr = 4'b0100; tick();
    chk("R5 iso cleared", ev_rd, 32'h0);
    ev_set[7] = 1'b1; tick();
    chk("R5 set port ignored", ev_rd, 32'h0);
    wipe();

    // R6: fatal error blocks culprit contexts only
    tag = "R6";
    ctx_dead = 4'b0010; tick();
    ctx_evt = 4'b1111; tick();
    chk("R6 culprit blocked", ev_rd & 32'h0100_000F, 32'h0100_000D);
    ev_clr = 32'h0100_000F; tick();
    ctx_evt = 4'b0010; tick();
    chk("R6 culprit forgotten", ev_rd & 32'h0100_000F, 32'h0000_0002);
    wipe();

    // R7: tardy acknowledge conditions
    tag = "R7";
    rx_fifo_pending = 1'b1; tick();
    chk("R7 disabled", ev_rd, 32'h0);
    tardy_en = 1'b1; tick();
    chk("R7 enabled no cond", ev_rd, 32'h0);
    tardy_en = 1'b1; phys_resp_busy = 1'b1; tick();
    chk("R7 resp busy", ev_rd, 32'h0800_0000);
    wipe();
    tardy_en = 1'b1; tardy_ack_sent = 1'b1; tick();
    chk("R7 ack sent", ev_rd, 32'h0800_0000);

    // R10: mask and master enable
    tag = "R10";
    mask_set = 32'h0800_0000; tick();
    chk("R10 no master", {31'h0, irq}, 32'h0);
    mask_set = 32'h8000_0000; mask_clr = 32'h8000_0000; tick();
    chk("R10 master on", {31'h0, irq}, 32'h1);
    ev_clr[27] = 1'b1; tick();
    chk("R10 event gone", {31'h0, irq}, 32'h0);
    wipe();

    // R8: general-purpose inputs need their own enables
    tag = "R8";
    gp_irq = 2'b01; gp_irq_en = 2'b10; tick();
    chk("R8 wrong enable", ev_rd, 32'h0);
    gp_irq = 2'b10; gp_irq_en = 2'b10; tick();
    chk("R8 enabled", ev_rd, 32'h4000_0000);
    wipe();

    // Mixed traffic against the reference model (R2 set/clear rules, all bits)
    tag = "R2";
    for (int k = 0; k < 4000; k++) begin
      evt_strobe      = $urandom & $urandom & $urandom;
      ev_set          = $urandom & $urandom & $urandom & $urandom;
      ev_clr          = $urandom & $urandom & $urandom;
      mask_set        = $urandom & $urandom & $urandom;
      mask_clr        = $urandom & $urandom & $urandom & $urandom;
      ctx_evt         = AC'($urandom & $urandom);
      ctx_dead        = AC'($urandom & $urandom & $urandom & $urandom);
      tardy_en        = 1'($urandom);
      rx_fifo_pending = 1'($urandom & $urandom);
      phys_resp_busy  = 1'($urandom & $urandom);
      tardy_ack_sent  = 1'($urandom & $urandom);
      gp_irq          = 2'($urandom);
      gp_irq_en       = 2'($urandom);
      iso_rx_strobe   = IC'($urandom & $urandom);
      iso_ev_clr      = IC'($urandom & $urandom);
      iso_mask_we     = 1'($urandom & $urandom);
      iso_mask_wdata  = IC'($urandom);
      tick();
    end

    finish_run();
  end
endmodule